// File: doc/BRIEF.md
# Paged Array Read Address Sequencer

This block produces the byte addresses for a read stream out of a flash array organised as 1024 pages of 264 bytes. A read command supplies a 24-bit address field: its low nine bits give the starting byte within a page, the next ten bits give the page, and the top five bits are reserved and have no effect. When `load_i` is pulsed, the block takes in the field and the selected read behaviour. It then waits through a dummy period of 32 serial bit times before it enters its data phase.

In the data phase, each byte-done strobe moves the position forward by one byte. The read behaviour is fixed when the field is loaded:
- **Single-page mode:** the byte position wraps back to byte 0 of the same page.
- **Continuous mode:** the byte position carries into the next page, and after the last page it returns to page 0. The step costs no extra cycles.

The position is also presented as a flat registered array address, page × 264 + byte, which drives the array RAM directly. Serial shifting and the array storage are outside this block.

Top module: `rd_addr_seq`

## Requirements
- R1: After reset, `page_o`, `col_o` and `arr_addr_o` are 0 and `data_phase_o` is 0.
- R2: On the clock edge where `load_i` is 1, the following take effect and are visible one cycle later:
  - `page_o` takes `addr_field_i[18:9]`.
  - `col_o` takes `addr_field_i[8:0]`.
  - `data_phase_o` clears.
  - Bits [23:19] have no effect on any output.
- R3: A loaded byte field value of 264 or more is reduced modulo 264 (for example 300 gives 36 and 511 gives 247).
- R4: `data_phase_o` rises on the edge that samples the 32nd `bit_tick_i` pulse after a load. Any `byte_done_i` seen while `data_phase_o` is 0 leaves all outputs unchanged.
- R5: In the data phase, a `byte_done_i` pulse on a column below 263 raises `col_o` by 1 and leaves `page_o` unchanged. The result is visible after one clock edge.
- R6: Continuous mode (`cont_mode_i` = 1 at load): a `byte_done_i` pulse at column 263 gives column 0 of the next page on the same edge.
- R7: Continuous mode: a `byte_done_i` pulse at page 1023, column 263 gives page 0, column 0, and `arr_addr_o` = 0.
- R8: Single-page mode (`cont_mode_i` = 0 at load): a `byte_done_i` pulse at column 263 gives column 0 of the same page.
- R9: `cont_mode_i` is sampled only when a load occurs. Changing it later does not alter the wrap behaviour.
- R10: `arr_addr_o` always equals `page_o` × 264 + `col_o`, and is updated on the same edge as `page_o` and `col_o`.
- R11: A load takes priority over `byte_done_i` and `bit_tick_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load the address field and mode, and restart the dummy period |
| addr_field_i | input | 24 | Address field: reserved [23:19], page [18:9], byte [8:0] |
| cont_mode_i | input | 1 | 1 = continuous array read, 0 = single-page read; sampled on load |
| bit_tick_i | input | 1 | One pulse per serial bit time, counted during the dummy period |
| byte_done_i | input | 1 | One pulse per output byte; advances the position in the data phase |
| data_phase_o | output | 1 | Dummy period over; byte strobes are honoured |
| page_o | output | 10 | Current page |
| col_o | output | 9 | Current byte within the page |
| arr_addr_o | output | 19 | Registered flat array byte address |

## Verification
The hardest situation to reach is the end-of-array wrap in continuous mode. It needs a load near page 1023, a complete 32-tick dummy period, and then byte strobes that cross column 263 exactly. Random loads almost never land there.

Directed loads are therefore used:
- Loads at page 1023 and at columns 258 to 262, in both modes, followed by a full dummy run and a short burst of strobes.
- A flip of the mode input partway through the burst.
- Strobes issued during the dummy period.
- A load issued in the same cycle as a strobe.

Random loads with random tick and strobe density cover the general stepping.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic {
    RD_PAGE = 1'b0,
    RD_CONT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rsq_field_dec.sv
module rsq_field_dec #(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGES      = 1024,
  parameter int unsigned PAGE_BYTES = 264,
  parameter int unsigned PAGE_W     = 10,
  parameter int unsigned COL_W      = 9
) (
  input  logic [ADDR_W-1:0] field_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o
);
  logic [PAGE_W-1:0] page_raw;
  logic [COL_W-1:0]  col_raw;
  logic              unused_rsv;

  assign col_raw    = field_i[COL_W-1:0];
  assign page_raw   = field_i[COL_W+PAGE_W-1:COL_W];
  assign unused_rsv = ^field_i[ADDR_W-1:COL_W+PAGE_W];

  // raw range is below twice the modulus, so one conditional subtract suffices
  always_comb begin
    if (32'(col_raw) >= 32'(PAGE_BYTES)) col_o = col_raw - COL_W'(PAGE_BYTES);
    else                                 col_o = col_raw;
    if (32'(page_raw) >= 32'(PAGES))     page_o = page_raw - PAGE_W'(PAGES);
    else                                 page_o = page_raw;
  end
endmodule

// File: rtl/rsq_dummy_cnt.sv
module rsq_dummy_cnt #(
  parameter int unsigned DUMMY_BITS = 32,
  localparam int unsigned CNT_W     = (DUMMY_BITS > 1) ? $clog2(DUMMY_BITS) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic tick_i,
  output logic data_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DUMMY_BITS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      data_q <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= '0;
      data_q <= 1'b0;
    end else if (!data_q && tick_i) begin
      if (cnt_q == CNT_LAST) data_q <= 1'b1;
      else                   cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign data_o = data_q;

  // R4: data phase opens only on the final dummy tick
  a_r4_dummy_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_q) |-> $past(tick_i) && ($past(cnt_q) == CNT_LAST) && !$past(load_i));

  // R2: a load always reopens the dummy period
  a_r2_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !data_q);
endmodule

// File: rtl/rsq_stepper.sv
module rsq_stepper
  import rsq_pkg::*;
#(
  parameter int unsigned PAGES      = 1024,
  parameter int unsigned PAGE_BYTES = 264,
  parameter int unsigned PAGE_W     = 10,
  parameter int unsigned COL_W      = 9,
  parameter int unsigned FLAT_W     = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PAGE_W-1:0] ld_page_i,
  input  logic [COL_W-1:0]  ld_col_i,
  input  rd_mode_e          ld_mode_i,
  input  logic              adv_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o,
  output logic [FLAT_W-1:0] flat_o
);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(PAGE_BYTES - 1);
  localparam logic [PAGE_W-1:0] PAGE_LAST = PAGE_W'(PAGES - 1);
  localparam logic [FLAT_W-1:0] PB_F      = FLAT_W'(PAGE_BYTES);

  logic [PAGE_W-1:0] page_q, page_d;
  logic [COL_W-1:0]  col_q, col_d;
  logic [FLAT_W-1:0] flat_q;
  rd_mode_e          mode_q, mode_d;

  always_comb begin
    page_d = page_q;
    col_d  = col_q;
    mode_d = mode_q;
    if (load_i) begin
      page_d = ld_page_i;
      col_d  = ld_col_i;
      mode_d = ld_mode_i;
    end else if (adv_i) begin
      if (col_q == COL_LAST) begin
        col_d = '0;
        if (mode_q == RD_CONT) page_d = (page_q == PAGE_LAST) ? '0 : page_q + 1'b1;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  // flat address built from next state: same edge as page/col, no extra latency
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_q <= '0;
      col_q  <= '0;
      mode_q <= RD_PAGE;
      flat_q <= '0;
    end else begin
      page_q <= page_d;
      col_q  <= col_d;
      mode_q <= mode_d;
      flat_q <= FLAT_W'(page_d) * PB_F + FLAT_W'(col_d);
    end
  end

  assign page_o = page_q;
  assign col_o  = col_q;
  assign flat_o = flat_q;

  a_r3_col_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(col_q) < 32'(PAGE_BYTES));

  a_r5_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && (col_q != COL_LAST) |=> (col_q == $past(col_q) + 1'b1) && $stable(page_q));

  a_r6_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && (mode_q == RD_CONT) && (col_q == COL_LAST) && (page_q != PAGE_LAST)
    |=> (col_q == '0) && (page_q == $past(page_q) + 1'b1));

  a_r7_array_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && (mode_q == RD_CONT) && (col_q == COL_LAST) && (page_q == PAGE_LAST)
    |=> (col_q == '0) && (page_q == '0));

  a_r8_same_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && !load_i && (mode_q == RD_PAGE) |=> $stable(page_q));

  a_r9_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_q));
endmodule

// File: rtl/rd_addr_seq.sv
module rd_addr_seq
  import rsq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 24,
  parameter int unsigned PAGES      = 1024,
  parameter int unsigned PAGE_BYTES = 264,
  parameter int unsigned DUMMY_BITS = 32,
  localparam int unsigned PAGE_W    = $clog2(PAGES),
  localparam int unsigned COL_W     = $clog2(PAGE_BYTES),
  localparam int unsigned FLAT_W    = $clog2(PAGES * PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_field_i,
  input  logic              cont_mode_i,
  input  logic              bit_tick_i,
  input  logic              byte_done_i,
  output logic              data_phase_o,
  output logic [PAGE_W-1:0] page_o,
  output logic [COL_W-1:0]  col_o,
  output logic [FLAT_W-1:0] arr_addr_o
);
  logic [PAGE_W-1:0] ld_page;
  logic [COL_W-1:0]  ld_col;
  logic              data_ph;
  rd_mode_e          ld_mode;

  assign ld_mode = cont_mode_i ? RD_CONT : RD_PAGE;

  rsq_field_dec #(
    .ADDR_W(ADDR_W), .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES),
    .PAGE_W(PAGE_W), .COL_W(COL_W)
  ) u_dec (
    .field_i(addr_field_i),
    .page_o (ld_page),
    .col_o  (ld_col)
  );

  rsq_dummy_cnt #(.DUMMY_BITS(DUMMY_BITS)) u_dummy (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .tick_i(bit_tick_i),
    .data_o(data_ph)
  );

  rsq_stepper #(
    .PAGES(PAGES), .PAGE_BYTES(PAGE_BYTES), .PAGE_W(PAGE_W),
    .COL_W(COL_W), .FLAT_W(FLAT_W)
  ) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load_i),
    .ld_page_i(ld_page),
    .ld_col_i (ld_col),
    .ld_mode_i(ld_mode),
    .adv_i    (byte_done_i & data_ph),
    .page_o   (page_o),
    .col_o    (col_o),
    .flat_o   (arr_addr_o)
  );

  assign data_phase_o = data_ph;

  a_r10_flat_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_addr_o == FLAT_W'(page_o) * FLAT_W'(PAGE_BYTES) + FLAT_W'(col_o));

  a_r4_no_step_in_dummy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_ph && !load_i |=> $stable(col_o) && $stable(page_o));

  a_r11_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (col_o == $past(ld_col)) && (page_o == $past(ld_page)) && !data_phase_o);
endmodule

// File: tb/tb_rd_addr_seq.sv
`timescale 1ns/1ps
module tb_rd_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [23:0] field = '0;
  logic        cmode = 1'b0;
  logic        tick = 1'b0;
  logic        bdone = 1'b0;
  logic        dph;
  logic [9:0]  page;
  logic [8:0]  col;
  logic [18:0] addr;

  int n_vec = 0;
  int n_bad = 0;
  int e_page = 0, e_col = 0, e_cnt = 0;
  bit e_dph = 0, e_mode = 0;

  always #5 clk = ~clk;

  rd_addr_seq dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .addr_field_i(field),
    .cont_mode_i(cmode), .bit_tick_i(tick), .byte_done_i(bdone),
    .data_phase_o(dph), .page_o(page), .col_o(col), .arr_addr_o(addr)
  );

  task automatic check(string tag);
    int e_addr;
    e_addr = e_page * 264 + e_col;
    n_vec++;
    if (int'(page) != e_page || int'(col) != e_col || int'(addr) != e_addr || dph != e_dph) begin
      n_bad++;
      $display("FAIL %s: page/col/addr/dph got %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
               tag, page, col, addr, dph, e_page, e_col, e_addr, e_dph);
    end
  endtask

  task automatic step(bit ld, logic [23:0] f, bit m, bit tk, bit bd, string tag);
    @(negedge clk);
    load = ld; field = f; cmode = m; tick = tk; bdone = bd;
    @(posedge clk);
    if (ld) begin
      e_page = int'(f[18:9]) % 1024;
      e_col  = int'(f[8:0]) % 264;
      e_mode = m; e_cnt = 0; e_dph = 0;
    end else begin
      if (e_dph && bd) begin
        if (e_col == 263) begin
          e_col = 0;
          if (e_mode) e_page = (e_page + 1) % 1024;
        end else e_col++;
      end
      if (!e_dph && tk) begin
        if (e_cnt == 31) e_dph = 1; else e_cnt++;
      end
    end
    #1 check(tag);
  endtask

  function automatic logic [23:0] fld(logic [4:0] rsv, int pg, int c);
    return {rsv, 10'(pg), 9'(c)};
  endfunction

  task automatic dummy(bit m, string tag);
    for (int i = 0; i < 32; i++) step(0, '0, m, 1, 0, tag);
  endtask

  task automatic bytes(int n, bit m, string tag);
    for (int i = 0; i < n; i++) step(0, '0, m, 0, 1, tag);
  endtask

  initial begin
    #1_500_000;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got hang exp finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'h5EED_1234);
    #12;
    check("R1 reset");
    @(negedge clk); rst_n = 1'b1;
    #1 check("R1 after release");

    // R2: field decode, reserved bits ignored
    step(1, fld(5'b10101, 5, 10), 0, 0, 0, "R2 load");
    step(1, fld(5'b01010, 5, 10), 0, 0, 0, "R2 reserved ignored");
    // R4: strobes during dummy ignored
    for (int i = 0; i < 3; i++) step(0, '0, 0, 0, 1, "R4 strobe in dummy");
    for (int i = 0; i < 31; i++) step(0, '0, 0, 1, 1, "R4 dummy count");
    step(0, '0, 0, 1, 1, "R4 dummy done");
    bytes(5, 0, "R5 step");

    // R3: modulo on byte field
    step(1, fld(0, 7, 300), 1, 0, 0, "R3 col 300");
    step(1, fld(0, 8, 511), 0, 0, 0, "R3 col 511");
    step(1, fld(0, 9, 264), 0, 0, 0, "R3 col 264");

    // R8: single-page wrap
    step(1, fld(0, 3, 258), 0, 0, 0, "R8 load");
    dummy(0, "R8 dummy");
    bytes(8, 0, "R8 same page wrap");

    // R6: page carry
    step(1, fld(0, 3, 260), 1, 0, 0, "R6 load");
    dummy(1, "R6 dummy");
    bytes(6, 1, "R6 next page");

    // R7: array wrap
    step(1, fld(5'b11111, 1023, 261), 1, 0, 0, "R7 load");
    dummy(1, "R7 dummy");
    bytes(5, 1, "R7 array wrap");

    // R9: mode input changes after load do nothing
    step(1, fld(0, 9, 262), 0, 0, 0, "R9 load page mode");
    dummy(1, "R9 dummy");
    bytes(4, 1, "R9 page mode held");
    step(1, fld(0, 1023, 262), 1, 0, 0, "R9 load cont mode");
    dummy(0, "R9 dummy");
    bytes(4, 0, "R9 cont mode held");

    // R11: load beats strobe and tick
    step(1, fld(0, 44, 100), 1, 1, 1, "R11 load with strobe");
    dummy(1, "R11 dummy");
    step(1, fld(0, 45, 200), 0, 1, 1, "R11 load in data phase");

    // R10 and general stepping under random stimulus
    for (int k = 0; k < 40; k++) begin
      logic [23:0] f;
      f = 24'($urandom);
      if (k % 4 == 0) f[8:0] = 9'(250 + $urandom_range(0, 13));
      step(1, f, 1'($urandom), 1'($urandom), 1'($urandom), "R10 random load");
      for (int c = 0; c < 100; c++)
        step(($urandom_range(0, 99) == 0), 24'($urandom), 1'($urandom),
             ($urandom_range(0, 3) != 0), 1'($urandom), "R10 random run");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule